// File: doc/BRIEF.md
# Serial Byte Transmitter with Line Break and Ready-to-Send Gating

This block turns a parallel data word into an asynchronous serial frame on a single output wire. One 31-bit setup word, applied as a static input, selects the bit period in system clocks, the data width (5 to 8 bits), one or two stop bits, the parity scheme, and whether ready-to-send flow control is honoured. A writer offers a word with a write strobe, and the block accepts it on a clock where it is not busy. The busy flag then stays high until the last stop bit has been sent.

Besides normal framing, the block can force the line low for as long as a break request is held, and this overrides any frame in progress. When flow control is enabled, a low ready-to-send input from the far end keeps a pending word waiting. A frame that has already started is not affected by it. The setup word is sampled when a word is accepted, so the frame format cannot change in the middle of a frame.

Top module: `serial_tx`

## Requirements
- R1: While reset is held and afterwards until the first acceptance, the line `tx_o` is high and `busy_o` is low.
- R2: A word is accepted only at a rising edge where `wr_i` is high, `busy_o` is low, `brk_i` is low and flow control permits. At any other time `data_i` and `wr_i` have no effect on the line.
- R3: A frame is a low start bit, then the data bits least significant first, then the optional parity bit, then the high stop bit(s). Each bit lasts `setup_i[23:0]` clocks, and a divisor of 0 is treated as 1. The start bit appears on the line in the cycle after acceptance.
- R4: `setup_i[29:28]` selects the data width: 0 selects 8 bits, 1 selects 7, 2 selects 6 and 3 selects 5.
- R5: `setup_i[27]` = 1 selects two stop bits. A value of 0 selects one stop bit.
- R6: `setup_i[26]` = 0 sends no parity bit. With `setup_i[26]` = 1 and `setup_i[25]` = 0, `setup_i[24]` = 0 gives odd parity and 1 gives even parity over the sent data bits. With `setup_i[26:25]` = 2'b11, the parity bit equals `setup_i[24]`.
- R7: `busy_o` rises in the cycle after acceptance and stays high for exactly (frame bits × divisor) cycles. It then falls, and the line is high while `busy_o` is low.
- R8: In the cycle after `brk_i` is seen high, the line is low and `busy_o` is high, and any frame in progress is dropped. In the cycle after `brk_i` is seen low again, the line is high and `busy_o` is low. A break request in the same cycle as a write wins, and the word is not accepted.
- R9: With `setup_i[30]` = 0, no new frame starts while `rts_i` is low. A frame already in progress completes unchanged.
- R10: With `setup_i[30]` = 1, `rts_i` is ignored.
- R11: Changes to `setup_i` after acceptance do not affect the frame in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| setup_i | input | 31 | Frame format, bit period and flow-control disable |
| data_i | input | 8 | Word to send |
| wr_i | input | 1 | Write strobe, held until accepted |
| brk_i | input | 1 | Hold the line in break while high |
| rts_i | input | 1 | Far end ready to receive (synchronous to clk) |
| tx_o | output | 1 | Serial output line |
| busy_o | output | 1 | Frame or break in progress |

## Verification
Three events can coincide in one cycle: a write request, a break request, and a change of the ready-to-send input. The bench raises `wr_i` and `brk_i` on the same edge while the block is idle. It then expects the line to go low with no frame queued, and expects the held word to be sent only after the break ends. The bench also drops `rts_i` in the middle of a frame and while a word is pending. A cycle-accurate behavioural model expands every accepted word into a queue of per-cycle line levels. The bench judges both the line and the busy flag against that model on every clock.

// File: rtl/stx_pkg.sv
// Package: shared constants and the decoded setup word for the serial transmitter.
// Assumes the setup layout [30] flow-off, [29:28] width code, [27] two stops,
// [26] parity on, [25] parity fixed, [24] parity select, [23:0] bit period.
package stx_pkg;
    localparam int SETUP_W = 31;
    localparam int DATA_W  = 8;
    localparam int DIV_W   = 24;
    localparam int FRAME_W = DATA_W + 4;
    localparam int CNT_W   = $clog2(FRAME_W + 1);

    typedef struct packed {
        logic             fc_off;
        logic [1:0]       len_code;
        logic             two_stop;
        logic             par_en;
        logic             par_fixed;
        logic             par_sel;
        logic [DIV_W-1:0] div;
    } cfg_t;

    function automatic cfg_t decode_setup(input logic [SETUP_W-1:0] s);
        cfg_t c;
        c.fc_off    = s[30];
        c.len_code  = s[29:28];
        c.two_stop  = s[27];
        c.par_en    = s[26];
        c.par_fixed = s[25];
        c.par_sel   = s[24];
        c.div       = s[DIV_W-1:0];
        return c;
    endfunction
endpackage

// File: rtl/stx_framer.sv
// Module: builds the full frame bit vector (bit 0 first on the wire) and its
// length from a data word and the format fields. Purely combinational.
// Assumes len_code selects DATA_W down to DATA_W-3 data bits.
module stx_framer
    import stx_pkg::*;
(
    input  logic [DATA_W-1:0]  data_i,
    input  logic [1:0]         len_code_i,
    input  logic               two_stop_i,
    input  logic               par_en_i,
    input  logic               par_fixed_i,
    input  logic               par_sel_i,
    output logic [FRAME_W-1:0] frame_o,
    output logic [CNT_W-1:0]   nbits_o
);
    logic [CNT_W-1:0]  width;
    logic [DATA_W-1:0] masked;
    logic              par_bit;

    assign width = CNT_W'(DATA_W) - CNT_W'(len_code_i);

    // Clear data bits beyond the selected width
    genvar gi;
    generate
        for (gi = 0; gi < DATA_W; gi++) begin : g_mask
            assign masked[gi] = (CNT_W'(gi) < width) ? data_i[gi] : 1'b0;
        end
    endgenerate

    // Parity: fixed level, or odd/even over the sent bits
    assign par_bit = par_fixed_i ? par_sel_i : (par_sel_i ? ^masked : ~^masked);

    // Place start, data, parity; remaining positions stay high as stop bits
    always_comb begin
        frame_o    = '1;
        frame_o[0] = 1'b0;
        for (int i = 0; i < DATA_W; i++) begin
            if (CNT_W'(i) < width) frame_o[i+1] = masked[i];
        end
        for (int k = 0; k < 4; k++) begin
            if (par_en_i && width == CNT_W'(DATA_W - 3 + k)) frame_o[DATA_W-2+k] = par_bit;
        end
    end

    assign nbits_o = CNT_W'(2) + width + CNT_W'(par_en_i) + CNT_W'(two_stop_i);
endmodule

// File: rtl/stx_bit_timer.sv
// Module: down-counter that measures one bit period. A load sets the count,
// which then falls to zero; expired_o is high while the count is zero.
// Assumes load_val_i is the period minus one.
module stx_bit_timer #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    output logic         expired_o
);
    logic [W-1:0] cnt;

    // Reload on request, else count down to zero and hold
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt <= '0;
        else if (load_i)       cnt <= load_val_i;
        else if (cnt != '0)    cnt <= cnt - 1'b1;
    end

    assign expired_o = (cnt == '0);
endmodule

// File: rtl/serial_tx.sv
// Module: serial transmitter top. Accepts a word, latches the format, shifts
// the frame out one bit per period, and handles break and ready-to-send.
// Assumes rts_i and brk_i are already synchronous to clk.
module serial_tx
    import stx_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [SETUP_W-1:0] setup_i,
    input  logic [DATA_W-1:0]  data_i,
    input  logic               wr_i,
    input  logic               brk_i,
    input  logic               rts_i,
    output logic               tx_o,
    output logic               busy_o
);
    cfg_t               cfg;
    logic [FRAME_W-1:0] frame;
    logic [CNT_W-1:0]   nbits;
    logic               busy_q, line_q, brk_q;
    logic [FRAME_W-2:0] shreg;
    logic [CNT_W-1:0]   left_q;
    logic [DIV_W-1:0]   div_m1_q, div_m1_new, load_val;
    logic               accept, step, load, expired;

    assign cfg        = decode_setup(setup_i);
    assign div_m1_new = (cfg.div == '0) ? '0 : cfg.div - 1'b1;
    assign accept     = wr_i && !busy_q && !brk_i && (rts_i || cfg.fc_off);
    assign step       = busy_q && !brk_q && !brk_i && expired;
    assign load       = accept || (step && left_q != '0);
    assign load_val   = accept ? div_m1_new : div_m1_q;

    stx_framer u_framer (
        .data_i      (data_i),
        .len_code_i  (cfg.len_code),
        .two_stop_i  (cfg.two_stop),
        .par_en_i    (cfg.par_en),
        .par_fixed_i (cfg.par_fixed),
        .par_sel_i   (cfg.par_sel),
        .frame_o     (frame),
        .nbits_o     (nbits)
    );

    stx_bit_timer #(.W(DIV_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load),
        .load_val_i (load_val),
        .expired_o  (expired)
    );

    // Sequencer: break has priority, then break exit, then launch or shift
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q   <= 1'b0;
            line_q   <= 1'b1;
            brk_q    <= 1'b0;
            shreg    <= '1;
            left_q   <= '0;
            div_m1_q <= '0;
        end else if (brk_i) begin
            brk_q  <= 1'b1;
            busy_q <= 1'b1;
            line_q <= 1'b0;
            left_q <= '0;
        end else if (brk_q) begin
            brk_q  <= 1'b0;
            busy_q <= 1'b0;
            line_q <= 1'b1;
        end else if (accept) begin
            busy_q   <= 1'b1;
            line_q   <= frame[0];
            shreg    <= frame[FRAME_W-1:1];
            left_q   <= nbits - 1'b1;
            div_m1_q <= div_m1_new;
        end else if (step) begin
            if (left_q == '0) begin
                busy_q <= 1'b0;
                line_q <= 1'b1;
            end else begin
                line_q <= shreg[0];
                shreg  <= {1'b1, shreg[FRAME_W-2:1]};
                left_q <= left_q - 1'b1;
            end
        end
    end

    assign tx_o   = line_q;
    assign busy_o = busy_q;

    AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> tx_o);                                              // R7
    AST_START_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !busy_o && !brk_i && (rts_i || setup_i[30])) |=> (busy_o && !tx_o)); // R3
    AST_BREAK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        brk_i |=> (busy_o && !tx_o));                                   // R8
    AST_RTS_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !brk_i && !rts_i && !setup_i[30]) |=> (!busy_o && tx_o)); // R9
    AST_LINE_HOLDS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && !brk_q && !brk_i && !expired) |=> $stable(tx_o));    // R3
endmodule

// File: tb/tb_serial_tx.sv
module tb_serial_tx;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [30:0] setup_i = '0;
    logic [7:0]  data_i = '0;
    logic        wr_i = 1'b0, brk_i = 1'b0, rts_i = 1'b1;
    logic        tx_o, busy_o;

    serial_tx dut (.clk(clk), .rst_n(rst_n), .setup_i(setup_i), .data_i(data_i),
                   .wr_i(wr_i), .brk_i(brk_i), .rts_i(rts_i), .tx_o(tx_o), .busy_o(busy_o));

    always #2.5 clk = ~clk;

    int    n_cmp = 0, n_bad = 0, cycles = 0;
    string cur_req = "R1";
    bit    q[$];
    bit    m_line = 1'b1, m_busy = 1'b0, m_brk = 1'b0, m_acc = 1'b0, m_valid = 1'b0;

    function automatic logic [30:0] mk(bit fc, int n, bit s, bit p, bit f, bit t, int div);
        logic [30:0] v;
        v = {fc, 2'(n), s, p, f, t, 24'(div)};
        return v;
    endfunction

    // Expand an accepted word into per-cycle line levels
    task automatic load_frame(logic [7:0] d, logic [30:0] su);
        int w, div, ones;
        bit bits[$];
        w = 8 - int'(su[29:28]);
        div = (su[23:0] == 0) ? 1 : int'(su[23:0]);
        bits.push_back(1'b0);
        ones = 0;
        for (int i = 0; i < w; i++) begin
            bits.push_back(d[i]);
            ones += int'(d[i]);
        end
        if (su[26]) begin
            if (su[25]) bits.push_back(su[24]);
            else if (su[24]) bits.push_back(ones % 2 == 1);
            else bits.push_back(ones % 2 == 0);
        end
        bits.push_back(1'b1);
        if (su[27]) bits.push_back(1'b1);
        q.delete();
        foreach (bits[k]) for (int c = 0; c < div; c++) q.push_back(bits[k]);
    endtask

    // Reference model advanced at every rising edge
    always @(posedge clk) begin
        m_valid = 1'b1;
        m_acc = 1'b0;
        cycles++;
        if (!rst_n) begin
            q.delete(); m_line = 1'b1; m_busy = 1'b0; m_brk = 1'b0;
        end else if (brk_i) begin
            q.delete(); m_line = 1'b0; m_busy = 1'b1; m_brk = 1'b1;
        end else if (m_brk) begin
            m_brk = 1'b0; m_busy = 1'b0; m_line = 1'b1;
        end else if (!m_busy) begin
            if (wr_i && (rts_i || setup_i[30])) begin
                load_frame(data_i, setup_i);
                m_line = q.pop_front(); m_busy = 1'b1; m_acc = 1'b1;
            end
        end else if (q.size() > 0) begin
            m_line = q.pop_front();
        end else begin
            m_busy = 1'b0; m_line = 1'b1;
        end
    end

    // Compare away from the active edge
    always @(negedge clk) begin
        if (m_valid) begin
            n_cmp++;
            if (tx_o !== m_line || busy_o !== m_busy) begin
                n_bad++;
                $display("FAIL %s: tx=%0b busy=%0b expected tx=%0b busy=%0b at cycle %0d",
                         cur_req, tx_o, busy_o, m_line, m_busy, cycles);
            end
        end
        if (cycles > 150000) begin
            n_bad++;
            $display("FAIL %s: watchdog expired, expected completion", cur_req);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic send(logic [7:0] d);
        @(negedge clk);
        data_i = d; wr_i = 1'b1;
        do @(negedge clk); while (!m_acc);
        wr_i = 1'b0;
    endtask

    task automatic drain();
        do @(negedge clk); while (m_busy);
        idle(2);
    endtask

    initial begin
        cur_req = "R1";
        setup_i = mk(0, 0, 0, 0, 0, 0, 4);
        idle(4);
        rst_n = 1'b1;
        idle(5);

        cur_req = "R3";
        send(8'hA5); drain();
        send(8'h3C); drain();

        cur_req = "R4";
        for (int n = 1; n < 4; n++) begin
            setup_i = mk(0, n, 0, 0, 0, 0, 3);
            send(8'hD6); drain();
        end

        cur_req = "R5";
        setup_i = mk(0, 2, 1, 0, 0, 0, 3);
        send(8'h5A); drain();

        cur_req = "R6";
        for (int m = 0; m < 4; m++) begin
            setup_i = mk(0, 0, 0, 1, m[1], m[0], 2);
            send(8'h07); drain();
            send(8'h81); drain();
        end
        setup_i = mk(0, 3, 0, 1, 0, 1, 2);
        send(8'hF3); drain();

        cur_req = "R7";
        setup_i = mk(0, 0, 1, 1, 0, 0, 1);
        send(8'h99); drain();
        setup_i = mk(0, 0, 0, 0, 0, 0, 0);
        send(8'h42); drain();

        cur_req = "R2";
        setup_i = mk(0, 1, 0, 0, 0, 0, 2);
        wr_i = 1'b1;
        for (int i = 0; i < 120; i++) begin
            data_i = 8'(i * 37);
            @(negedge clk);
        end
        wr_i = 1'b0;
        drain();

        cur_req = "R8";
        setup_i = mk(0, 0, 0, 0, 0, 0, 4);
        @(negedge clk); data_i = 8'hC3; wr_i = 1'b1;
        do @(negedge clk); while (!m_acc);
        wr_i = 1'b0;
        idle(9);
        brk_i = 1'b1; idle(12); brk_i = 1'b0;
        idle(3);
        data_i = 8'h6E; wr_i = 1'b1; brk_i = 1'b1;
        idle(10);
        brk_i = 1'b0;
        do @(negedge clk); while (!m_acc);
        wr_i = 1'b0;
        drain();

        cur_req = "R9";
        rts_i = 1'b0;
        data_i = 8'h11; wr_i = 1'b1;
        idle(25);
        rts_i = 1'b1;
        do @(negedge clk); while (!m_acc);
        wr_i = 1'b0;
        idle(6);
        rts_i = 1'b0;
        drain();
        rts_i = 1'b1;

        cur_req = "R10";
        setup_i = mk(1, 0, 0, 0, 0, 0, 3);
        rts_i = 1'b0;
        send(8'hE8); drain();
        rts_i = 1'b1;

        cur_req = "R11";
        setup_i = mk(0, 0, 0, 1, 1, 1, 3);
        send(8'h2D);
        idle(4);
        setup_i = mk(0, 3, 1, 0, 0, 0, 7);
        idle(3);
        data_i = 8'hFF;
        drain();
        send(8'h2D); drain();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule